// File: doc/BRIEF.md
# Lane Fetch Command Sequencer

This block is the command front end of one execution lane. It accepts block-fetch commands from the control processor and thread-fetch requests raised by the lane's own virtual processors (VPs). For every fetch it does one tag check against a small, fully associative cache of instruction blocks. On a miss it asks a fill port for the block and waits for it. It then plays the block out as a stream of instructions, each tagged with the VP it runs for.

A vector-fetch plays the addressed block once for every resident VP, in ascending VP order. A thread-fetch plays the block only for the VP that asked for it. A VP asks for its next block by issuing a fetch instruction inside its current block. The fetch can be predicated on a per-VP predicate flag from the datapath. When a block finishes without a taken fetch, that VP's thread stops. All pending thread work is drained before the next control-processor command is accepted.

The fetch instruction uses bit 31 as the fetch flag and bit 30 as the predicate-enable flag. Its low 12 bits hold the target block address.

Top module: `lane_fetch_seq`

## Requirements
- R1: After reset, `vf_ready` is 1 and `iss_valid` and `fill_req_valid` are 0.
- R2: A vector-fetch issues the block for VP 0, 1, 2, 3 in that order. Each VP gets all 8 instructions in slot order, and the VPs follow back to back with no idle cycle between them.
- R3: A thread-fetch issues its block only for the requesting VP, 8 instructions tagged with that VP index.
- R4: The tag is checked once per fetch, not once per VP or per instruction. On a hit, the first instruction appears in the second cycle after the command is accepted.
- R5: On a miss, `fill_req_valid` is high for exactly one cycle and `fill_req_addr` carries the block address. The 8 response beats fill the entry in order. The first instruction appears in the cycle after the edge that takes the last beat, which is cycle 10 after acceptance when the beats arrive back to back.
- R6: No instruction is issued while a fill is in progress.
- R7: An issued instruction with bit 31 = 1 and bit 30 = 0 records its low 12 bits as the pending thread-fetch address of the issuing VP. A block that issues no taken fetch ends that VP's thread.
- R8: An instruction with bit 31 = 1 and bit 30 = 1 is taken only when `vp_pred` bit [vp] is 1. Otherwise it has no effect.
- R9: `vf_ready` is 1 only when the sequencer is idle and no thread-fetch is pending. A waiting vector-fetch command is held until all threads have finished.
- R10: Pending thread-fetches are served round-robin, starting from the VP after the one served last.
- R11: The cache holds 4 blocks and replaces entries in rotation: 0, 1, 2, 3, then 0 again. A fifth distinct block therefore evicts the first one.
- R12: When a block issues several taken fetches for one VP, the last one decides the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vf_valid | input | 1 | Vector-fetch command present |
| vf_addr | input | 12 | Block address of the vector-fetch |
| vf_ready | output | 1 | Command accepted on this edge when `vf_valid` is also high |
| vp_pred | input | 4 | Per-VP predicate flags for predicated fetches |
| fill_req_valid | output | 1 | One-cycle block fill request |
| fill_req_addr | output | 12 | Block address to fill |
| fill_rsp_valid | input | 1 | Fill beat present |
| fill_rsp_data | input | 32 | Fill beat: one instruction, slot order |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_vp | output | 2 | VP index the instruction runs for |
| iss_instr | output | 32 | Issued instruction |

## Verification
A command is accepted at a clock edge. On a hit its first instruction is due on the second falling edge after acceptance. On a miss it is due on the tenth, because the responder drives the 8 beats back to back starting on the falling edge where it sees the request. The bench counts falling edges from the acceptance edge and compares the count with the hit or miss latency predicted by its own four-entry rotating cache model. All outputs are sampled on falling edges, and every issued instruction is compared in order against a queue of expected (VP, instruction) pairs. That queue is built from the ascending-VP, round-robin and last-fetch-wins rules, so stalls for ready or fills never shift which result is expected.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;

  // A fetch instruction redirects its VP unless it is predicated and the
  // predicate flag of that VP is clear.
  function automatic logic fetch_taken(input logic is_fetch,
                                       input logic is_pred,
                                       input logic pred_flag);
    return is_fetch && (!is_pred || pred_flag);
  endfunction

  // Next index in a rotation over n slots.
  function automatic int unsigned rot_next(input int unsigned cur,
                                           input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/lfs_block_cache.sv
module lfs_block_cache #(
  parameter int NUM_ENTRIES = 4,
  parameter int BLK_LEN     = 8,
  parameter int ADDR_W      = 12,
  parameter int INSTR_W     = 32,
  parameter int ENT_W       = 2,
  parameter int IDX_W       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  lk_addr,
  output logic               lk_hit,
  output logic [ENT_W-1:0]   lk_entry,
  input  logic               fill_start,
  input  logic               fill_beat_valid,
  input  logic [INSTR_W-1:0] fill_beat_data,
  output logic               fill_done,
  output logic [ENT_W-1:0]   fill_entry,
  output logic               filling,
  input  logic [ENT_W-1:0]   rd_entry,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [INSTR_W-1:0] rd_instr
);
  import lfs_pkg::*;

  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(BLK_LEN - 1);

  logic [ADDR_W-1:0]  tag_q   [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] vld_q;
  logic [INSTR_W-1:0] data_q  [NUM_ENTRIES][BLK_LEN];
  logic [ENT_W-1:0]   victim_q;
  logic [IDX_W-1:0]   beat_q;
  logic               filling_q;
  logic [NUM_ENTRIES-1:0] hit_vec;
  logic               beat_we;

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : g_tag
      assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_addr);
    end
  endgenerate

  always_comb begin
    lk_entry = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit_vec[i]) lk_entry = ENT_W'(i);
    end
  end

  assign lk_hit     = |hit_vec;
  assign beat_we    = filling_q && fill_beat_valid;
  assign fill_done  = beat_we && (beat_q == LAST_BEAT);
  assign fill_entry = victim_q;
  assign filling    = filling_q;
  assign rd_instr   = data_q[rd_entry][rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= '0;
      victim_q  <= '0;
      beat_q    <= '0;
      filling_q <= 1'b0;
      for (int i = 0; i < NUM_ENTRIES; i++) tag_q[i] <= '0;
    end else if (fill_start) begin
      filling_q       <= 1'b1;
      beat_q          <= '0;
      vld_q[victim_q] <= 1'b0;
      tag_q[victim_q] <= lk_addr;
    end else if (beat_we) begin
      if (beat_q == LAST_BEAT) begin
        filling_q       <= 1'b0;
        vld_q[victim_q] <= 1'b1;
        victim_q        <= ENT_W'(rot_next(int'(victim_q), NUM_ENTRIES));
      end else begin
        beat_q <= beat_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (beat_we) data_q[victim_q][beat_q] <= fill_beat_data;
  end

  // R11
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R5
  fill_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filling_q |-> !lk_hit);

endmodule

// File: rtl/lfs_pending_table.sv
module lfs_pending_table #(
  parameter int NUM_VP = 4,
  parameter int ADDR_W = 12,
  parameter int VP_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [VP_W-1:0]   set_vp,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              take,
  output logic              any_pend,
  output logic [VP_W-1:0]   grant_vp,
  output logic [ADDR_W-1:0] grant_addr
);
  import lfs_pkg::*;

  logic [NUM_VP-1:0] pend_q;
  logic [ADDR_W-1:0] addr_q [NUM_VP];
  logic [VP_W-1:0]   ptr_q;

  // First pending VP at or after the rotation pointer.
  function automatic logic [VP_W-1:0] rr_pick(input logic [NUM_VP-1:0] pend,
                                              input logic [VP_W-1:0]   ptr);
    logic [VP_W-1:0] sel;
    logic            found;
    sel   = ptr;
    found = 1'b0;
    for (int off = 0; off < NUM_VP; off++) begin
      int c;
      c = (int'(ptr) + off) % NUM_VP;
      if (!found && pend[c]) begin
        sel   = VP_W'(c);
        found = 1'b1;
      end
    end
    return sel;
  endfunction

  assign any_pend   = |pend_q;
  assign grant_vp   = rr_pick(pend_q, ptr_q);
  assign grant_addr = addr_q[grant_vp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ptr_q  <= '0;
      for (int i = 0; i < NUM_VP; i++) addr_q[i] <= '0;
    end else begin
      if (take) begin
        pend_q[grant_vp] <= 1'b0;
        ptr_q            <= VP_W'(rot_next(int'(grant_vp), NUM_VP));
      end
      if (set_valid) begin
        pend_q[set_vp] <= 1'b1;
        addr_q[set_vp] <= set_addr;
      end
    end
  end

  // R10
  grant_rr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pend_q[grant_vp] && (grant_vp == ptr_q || !pend_q[ptr_q])));

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !set_valid) |=> $stable(pend_q));

endmodule

// File: rtl/lfs_issue_ctrl.sv
module lfs_issue_ctrl #(
  parameter int NUM_VP  = 4,
  parameter int BLK_LEN = 8,
  parameter int ADDR_W  = 12,
  parameter int VP_W    = 2,
  parameter int ENT_W   = 2,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vf_valid,
  input  logic [ADDR_W-1:0] vf_addr,
  output logic              vf_ready,
  input  logic              any_pend,
  input  logic [VP_W-1:0]   grant_vp,
  input  logic [ADDR_W-1:0] grant_addr,
  output logic              take,
  output logic [ADDR_W-1:0] blk_addr,
  input  logic              lk_hit,
  input  logic [ENT_W-1:0]  lk_entry,
  output logic              fill_start,
  output logic              fill_req_valid,
  input  logic              fill_done,
  input  logic [ENT_W-1:0]  fill_entry,
  output logic [ENT_W-1:0]  rd_entry,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              fetch_bit,
  input  logic              pred_bit,
  input  logic [ADDR_W-1:0] fetch_tgt,
  input  logic [NUM_VP-1:0] vp_pred,
  output logic              iss_valid,
  output logic [VP_W-1:0]   iss_vp,
  output logic              set_valid,
  output logic [VP_W-1:0]   set_vp,
  output logic [ADDR_W-1:0] set_addr
);
  import lfs_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_LEN - 1);
  localparam logic [VP_W-1:0]  LAST_VP  = VP_W'(NUM_VP - 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              is_vec_q;
  logic [VP_W-1:0]   vp_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ENT_W-1:0]  entry_q;
  logic              req_sent_q;

  assign vf_ready       = (state_q == ST_IDLE) && !any_pend;
  assign take           = (state_q == ST_IDLE) && any_pend;
  assign fill_start     = (state_q == ST_LOOKUP) && !lk_hit;
  assign fill_req_valid = (state_q == ST_FILL) && !req_sent_q;
  assign iss_valid      = (state_q == ST_RUN);
  assign iss_vp         = vp_q;
  assign blk_addr       = addr_q;
  assign rd_entry       = entry_q;
  assign rd_idx         = idx_q;
  assign set_valid      = iss_valid && fetch_taken(fetch_bit, pred_bit, vp_pred[vp_q]);
  assign set_vp         = vp_q;
  assign set_addr       = fetch_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      is_vec_q   <= 1'b0;
      vp_q       <= '0;
      idx_q      <= '0;
      entry_q    <= '0;
      req_sent_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (any_pend) begin
            addr_q   <= grant_addr;
            vp_q     <= grant_vp;
            is_vec_q <= 1'b0;
            state_q  <= ST_LOOKUP;
          end else if (vf_valid) begin
            addr_q   <= vf_addr;
            vp_q     <= '0;
            is_vec_q <= 1'b1;
            state_q  <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (lk_hit) begin
            entry_q <= lk_entry;
            idx_q   <= '0;
            state_q <= ST_RUN;
          end else begin
            req_sent_q <= 1'b0;
            state_q    <= ST_FILL;
          end
        end
        ST_FILL: begin
          req_sent_q <= 1'b1;
          if (fill_done) begin
            entry_q <= fill_entry;
            idx_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (idx_q == LAST_IDX) begin
            idx_q <= '0;
            if (is_vec_q && vp_q != LAST_VP) vp_q <= vp_q + VP_W'(1);
            else                              state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid) && $past(idx_q) != LAST_IDX)
      |-> (idx_q == $past(idx_q) + IDX_W'(1) && vp_q == $past(vp_q)));

  // R3
  thread_vp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !is_vec_q && $past(iss_valid)) |-> $stable(vp_q));

endmodule

// File: rtl/lane_fetch_seq.sv
module lane_fetch_seq #(
  parameter int NUM_VP      = 4,
  parameter int NUM_ENTRIES = 4,
  parameter int BLK_LEN     = 8,
  parameter int ADDR_W      = 12,
  parameter int INSTR_W     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vf_valid,
  input  logic [ADDR_W-1:0]  vf_addr,
  output logic               vf_ready,
  input  logic [NUM_VP-1:0]  vp_pred,
  output logic               fill_req_valid,
  output logic [ADDR_W-1:0]  fill_req_addr,
  input  logic               fill_rsp_valid,
  input  logic [INSTR_W-1:0] fill_rsp_data,
  output logic               iss_valid,
  output logic [$clog2(NUM_VP)-1:0] iss_vp,
  output logic [INSTR_W-1:0] iss_instr
);
  localparam int VP_W  = (NUM_VP > 1) ? $clog2(NUM_VP) : 1;
  localparam int ENT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int IDX_W = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam int FETCH_BIT = INSTR_W - 1;
  localparam int PRED_BIT  = INSTR_W - 2;

  logic              any_pend, take, set_valid;
  logic [VP_W-1:0]   grant_vp, set_vp;
  logic [ADDR_W-1:0] grant_addr, set_addr, blk_addr;
  logic              lk_hit, fill_start, fill_done, cache_filling;
  logic [ENT_W-1:0]  lk_entry, fill_entry, rd_entry;
  logic [IDX_W-1:0]  rd_idx;
  logic [INSTR_W-1:0] rd_instr;

  assign fill_req_addr = blk_addr;
  assign iss_instr     = rd_instr;

  lfs_block_cache #(
    .NUM_ENTRIES(NUM_ENTRIES), .BLK_LEN(BLK_LEN), .ADDR_W(ADDR_W),
    .INSTR_W(INSTR_W), .ENT_W(ENT_W), .IDX_W(IDX_W)
  ) cache_i (
    .clk(clk), .rst_n(rst_n),
    .lk_addr(blk_addr), .lk_hit(lk_hit), .lk_entry(lk_entry),
    .fill_start(fill_start), .fill_beat_valid(fill_rsp_valid),
    .fill_beat_data(fill_rsp_data), .fill_done(fill_done),
    .fill_entry(fill_entry), .filling(cache_filling),
    .rd_entry(rd_entry), .rd_idx(rd_idx), .rd_instr(rd_instr)
  );

  lfs_pending_table #(
    .NUM_VP(NUM_VP), .ADDR_W(ADDR_W), .VP_W(VP_W)
  ) pend_i (
    .clk(clk), .rst_n(rst_n),
    .set_valid(set_valid), .set_vp(set_vp), .set_addr(set_addr),
    .take(take), .any_pend(any_pend), .grant_vp(grant_vp),
    .grant_addr(grant_addr)
  );

  lfs_issue_ctrl #(
    .NUM_VP(NUM_VP), .BLK_LEN(BLK_LEN), .ADDR_W(ADDR_W),
    .VP_W(VP_W), .ENT_W(ENT_W), .IDX_W(IDX_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .vf_valid(vf_valid), .vf_addr(vf_addr), .vf_ready(vf_ready),
    .any_pend(any_pend), .grant_vp(grant_vp), .grant_addr(grant_addr),
    .take(take), .blk_addr(blk_addr),
    .lk_hit(lk_hit), .lk_entry(lk_entry),
    .fill_start(fill_start), .fill_req_valid(fill_req_valid),
    .fill_done(fill_done), .fill_entry(fill_entry),
    .rd_entry(rd_entry), .rd_idx(rd_idx),
    .fetch_bit(rd_instr[FETCH_BIT]), .pred_bit(rd_instr[PRED_BIT]),
    .fetch_tgt(rd_instr[ADDR_W-1:0]), .vp_pred(vp_pred),
    .iss_valid(iss_valid), .iss_vp(iss_vp),
    .set_valid(set_valid), .set_vp(set_vp), .set_addr(set_addr)
  );

  // R6
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_filling |-> !iss_valid);

  // R9
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vf_ready |-> (!iss_valid && !cache_filling));

  // R2
  vp_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid) && iss_vp != $past(iss_vp))
      |-> (iss_vp == $past(iss_vp) + VP_W'(1)));

  // R5
  fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |=> !fill_req_valid);

endmodule

// File: tb/lane_fetch_seq_tb.sv
module lane_fetch_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVP = 4;
  localparam int BLK = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vf_valid = 1'b0;
  logic [11:0] vf_addr = '0;
  logic        vf_ready;
  logic [3:0]  vp_pred = '0;
  logic        fill_req_valid;
  logic [11:0] fill_req_addr;
  logic        fill_rsp_valid = 1'b0;
  logic [31:0] fill_rsp_data = '0;
  logic        iss_valid;
  logic [1:0]  iss_vp;
  logic [31:0] iss_instr;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .vf_valid(vf_valid), .vf_addr(vf_addr),
    .vf_ready(vf_ready), .vp_pred(vp_pred),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data),
    .iss_valid(iss_valid), .iss_vp(iss_vp), .iss_instr(iss_instr)
  );

  typedef struct {
    logic [1:0]  vp;
    logic [31:0] instr;
    string       req;
  } exp_t;

  exp_t        exp_q[$];
  int          n_chk = 0, n_err = 0;
  int          fill_cnt = 0, exp_fill_cnt = 0;
  logic [11:0] last_req_addr = '0;
  logic [11:0] m_tag[4];
  bit          m_vld[4];
  int          m_vic = 0;

  function automatic logic [31:0] mk_fetch(input bit pred, input logic [11:0] tgt);
    return {1'b1, pred, 18'd0, tgt};
  endfunction

  // Block contents: plain instructions, plus fetch instructions in the
  // 0xAxx (chain down), 0xBxx (predicated) and 0xC00 (two fetches) blocks.
  function automatic logic [31:0] instr_of(input logic [11:0] a, input int b);
    if (a[11:8] == 4'hA && a[3:0] != 4'h0 && b == 3) return mk_fetch(1'b0, a - 12'd1);
    if (a[11:8] == 4'hB && b == 6) return mk_fetch(1'b1, {8'hA0, a[3:0]});
    if (a == 12'hC00 && b == 2) return mk_fetch(1'b0, 12'h111);
    if (a == 12'hC00 && b == 7) return mk_fetch(1'b0, 12'h030);
    return {2'b00, 6'(b), a, a ^ 12'(b * 37)};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  function automatic bit model_fetch(input logic [11:0] a);
    for (int i = 0; i < 4; i++) if (m_vld[i] && m_tag[i] == a) return 1'b1;
    m_tag[m_vic] = a;
    m_vld[m_vic] = 1'b1;
    m_vic = (m_vic + 1) % 4;
    exp_fill_cnt++;
    return 1'b0;
  endfunction

  task automatic push_blk(input logic [1:0] vp, input logic [11:0] a, input string req);
    for (int b = 0; b < BLK; b++) begin
      exp_t e;
      e.vp = vp; e.instr = instr_of(a, b); e.req = req;
      exp_q.push_back(e);
    end
  endtask

  task automatic exp_thread(input logic [1:0] vp, input logic [11:0] a, input string req);
    push_blk(vp, a, req);
    void'(model_fetch(a));
  endtask

  task automatic vfetch(input logic [11:0] a);
    bit hit;
    int lat;
    for (int v = 0; v < NVP; v++) push_blk(2'(v), a, "R2");
    hit = model_fetch(a);
    @(negedge clk);
    vf_valid = 1'b1;
    vf_addr  = a;
    while (!vf_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    vf_valid = 1'b0;
    lat = 1;
    while (!iss_valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    if (hit) check(lat == 2, "R4", lat, 2);
    else begin
      check(lat == 2 + BLK, "R5", lat, 2 + BLK);
      check(last_req_addr == a, "R5", last_req_addr, a);
    end
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || !vf_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // Fill responder: back-to-back beats starting where the request is seen.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && fill_req_valid) begin
        logic [11:0] a;
        a = fill_req_addr;
        fill_cnt++;
        last_req_addr = a;
        for (int b = 0; b < BLK; b++) begin
          fill_rsp_valid = 1'b1;
          fill_rsp_data  = instr_of(a, b);
          @(negedge clk);
          check(!fill_req_valid, "R5", fill_req_valid, 0);
          check(!iss_valid || b == BLK - 1, "R6", iss_valid, 0);
        end
        fill_rsp_valid = 1'b0;
      end
    end
  end

  // Issue monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && iss_valid) begin
        check(!vf_ready, "R9", vf_ready, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", {iss_vp, iss_instr}, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(iss_vp == e.vp && iss_instr == e.instr, e.req,
                {iss_vp, iss_instr}, {e.vp, e.instr});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R9", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < 4; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; end
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(vf_ready == 1'b1, "R1", vf_ready, 1);
    check(iss_valid == 1'b0, "R1", iss_valid, 0);
    check(fill_req_valid == 1'b0, "R1", fill_req_valid, 0);

    // R11 rotating replacement: five distinct blocks, then revisit
    for (int k = 0; k < 5; k++) vfetch(12'h010 + 12'(k));
    vfetch(12'h011);   // R4 hit
    vfetch(12'h010);   // R11 evicted by 0x014, misses again
    wait_idle();
    check(fill_cnt == exp_fill_cnt, "R11", fill_cnt, exp_fill_cnt);

    // R7 / R3 / R9: every VP chains to 0xA00, a held command waits
    vfetch(12'hA01);
    for (int v = 0; v < NVP; v++) exp_thread(2'(v), 12'hA00, "R3");
    vfetch(12'h020);
    wait_idle();

    // R8 / R10: predicate on VP1 and VP3 only, chains interleave
    vp_pred = 4'b1010;
    vfetch(12'hB02);
    exp_thread(2'd1, 12'hA02, "R10");
    exp_thread(2'd3, 12'hA02, "R10");
    exp_thread(2'd1, 12'hA01, "R10");
    exp_thread(2'd3, 12'hA01, "R10");
    exp_thread(2'd1, 12'hA00, "R10");
    exp_thread(2'd3, 12'hA00, "R10");
    wait_idle();
    // R8 predicate clear: no thread follows
    vp_pred = 4'b0000;
    vfetch(12'hB02);
    vfetch(12'h021);
    wait_idle();

    // R12 two taken fetches: the later target 0x030 wins for every VP
    vfetch(12'hC00);
    for (int v = 0; v < NVP; v++) exp_thread(2'(v), 12'h030, "R12");
    wait_idle();

    // Random vector-fetches over eight plain blocks, random predicates
    for (int i = 0; i < 24; i++) begin
      vp_pred = 4'($urandom);
      repeat ($urandom % 3) @(negedge clk);
      vfetch(12'h020 + 12'($urandom % 8));
    end
    wait_idle();
    check(fill_cnt == exp_fill_cnt, "R11", fill_cnt, exp_fill_cnt);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule